// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Prescaler

This block drives a bank of pulse-width-modulated outputs from one common time base. A single prescaler divides the input clock down to a local tick, and one shared 8-bit counter steps through a fixed frame of 256 ticks. Every channel compares that counter against its own 8-bit duty value, so all channels run at the same period and their pulses start on the same clock. The only way to change the period at a given input clock is to change the prescale value.

Software reaches the block through a plain 32-bit register port. Addresses are byte addresses with a word stride of 4. One control word carries the 8-bit prescale, split into two 4-bit fields, and a single enable bit that starts or stops every channel at once. Each channel also has its own duty word. A new duty value is held in a shadow register and takes effect only when the frame wraps, so no output ever produces a truncated or doubled pulse.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous reset, every output is low and the control word and all duty words read back as zero.
- R2: The control word is at byte offset 0x50. Prescale bits 3:0 are in bits 3:0 and prescale bits 7:4 are in bits 14:11. The global enable is bit 9. All other bits are dropped on write and read as zero, so a readback equals the written value AND 0x7A0F.
- R3: The duty word for channel n is at byte offset 4·n. Its low 8 bits read back as written and its upper bits read as zero.
- R4: While enabled, every output repeats with a period of exactly 256·(P+1) clock cycles, where P is the 8-bit prescale.
- R5: While enabled, a channel with duty D stays high for (D+1)·(P+1) clock cycles per period. A duty of 0 therefore gives a pulse one local tick long.
- R6: A duty of 255 keeps the output high without a break while the block is enabled.
- R7: With the enable bit at 0, every output is low, whatever the duty values, and the shared counters rest at zero.
- R8: When the block is enabled, all channels rise in the same clock cycle, one cycle after the enabling write, and every later rise is also common to all channels.
- R9: A duty write made during a period does not change the pulse already running. The new value first applies in the period after the next frame wrap.
- R10: A write to an offset that maps to no register changes no register, and reading such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, registered, valid one cycle after the address |
| pwm_out | output | NUM_CH | One registered PWM output per channel |

## Verification
The assertions assume that a write strobe lasts one cycle with a word-aligned address. They also assume that no duty write arrives in the same cycle as the write that sets the enable bit, because the loaded duty is the one present while the block was still disabled. The bench drives single, spaced writes from tasks, always on the falling clock edge. It changes the prescale only while the block runs, which the terminal-count comparison absorbs. Pulse widths are measured only from a fresh rising edge that follows each change.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int PS_W        = 8;
  localparam int CNT_W       = 8;
  localparam int DATA_W      = 32;
  localparam int CTRL_WORD   = 20;      // byte offset 0x50
  localparam int PS_LO_LSB   = 0;
  localparam int PS_HI_LSB   = 11;
  localparam int EN_BIT      = 9;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_7A0F;
  localparam logic [CNT_W-1:0]  CNT_LAST  = {CNT_W{1'b1}};
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          enable,
  output logic [PS_W-1:0]               prescale,
  output logic [NUM_CH-1:0][CNT_W-1:0]  duty_shadow
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_ctrl;
  logic              hit_any;

  assign word     = addr[ADDR_W-1:2];
  assign hit_ctrl = (int'(word) == CTRL_WORD);

  always_ff @(posedge clk) begin
    if (rst)                ctrl_q <= '0;
    else if (we && hit_ctrl) ctrl_q <= wdata & CTRL_MASK;
  end

  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_duty
      always_ff @(posedge clk) begin
        if (rst)                        duty_shadow[n] <= '0;
        else if (we && int'(word) == n) duty_shadow[n] <= wdata[CNT_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rd_mux  = '0;
    hit_any = hit_ctrl;
    if (hit_ctrl) rd_mux = ctrl_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(word) == i) begin
        rd_mux  = {{(DATA_W-CNT_W){1'b0}}, duty_shadow[i]};
        hit_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign enable   = ctrl_q[EN_BIT];
  assign prescale = {ctrl_q[PS_HI_LSB +: 4], ctrl_q[PS_LO_LSB +: 4]};

  // R10: a write to an unmapped word leaves the control word alone
  a_r10_unmapped_ctrl: assert property (@(posedge clk) disable iff (rst)
    (we && !hit_any) |=> $stable(ctrl_q));

  // R3: a write to duty word 0 is visible in the shadow next cycle
  a_r3_duty_write: assert property (@(posedge clk) disable iff (rst)
    (we && word == '0) |=> duty_shadow[0] == $past(wdata[CNT_W-1:0]));

  // R2: the enable seen by the time base follows the control write
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    (we && hit_ctrl) |=> enable == $past(wdata[EN_BIT]));
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PS_W-1:0]  prescale,
  output logic [CNT_W-1:0] period_cnt,
  output logic             load
);
  logic [PS_W-1:0] tick_q;
  logic            tick_end;

  // terminal compare uses >= so a prescale lowered mid-tick recovers at once
  assign tick_end = (tick_q >= prescale);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tick_q     <= '0;
      period_cnt <= '0;
    end else if (tick_end) begin
      tick_q     <= '0;
      period_cnt <= period_cnt + 1'b1;
    end else begin
      tick_q     <= tick_q + 1'b1;
    end
  end

  // shadow duty values are copied while idle and on each frame wrap
  assign load = !enable || (tick_end && period_cnt == CNT_LAST);

  // R7: disabled time base rests at zero
  a_r7_counters_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (tick_q == '0 && period_cnt == '0));

  // R4: the frame counter moves only on a local tick
  a_r4_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick_end) |=> $stable(period_cnt));
endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             load,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [CNT_W-1:0] duty_shadow,
  output logic             pwm
);
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst)       active_q <= '0;
    else if (load) active_q <= duty_shadow;
  end

  // inclusive compare: duty 0 -> one tick, duty 255 -> whole frame
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= enable && (period_cnt <= active_q);
  end

  // R9: the active duty only changes on a load strobe
  a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active_q));

  // R8: every rising edge starts at frame position zero
  a_r8_rise_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm) |-> $past(period_cnt) == '0);

  // R6: full-scale duty keeps the output high
  a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
    (enable && active_q == CNT_LAST) |=> pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,   // must stay below CTRL_WORD
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                         enable;
  logic [PS_W-1:0]              prescale;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_shadow;
  logic [CNT_W-1:0]             period_cnt;
  logic                         load;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .enable(enable), .prescale(prescale),
    .duty_shadow(duty_shadow)
  );

  pwm_bank_timebase u_timebase (
    .clk(clk), .rst(rst), .enable(enable), .prescale(prescale),
    .period_cnt(period_cnt), .load(load)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_bank_channel u_ch (
        .clk(clk), .rst(rst), .enable(enable), .load(load),
        .period_cnt(period_cnt), .duty_shadow(duty_shadow[c]),
        .pwm(pwm_out[c])
      );
    end
  endgenerate

  // R7: outputs drop the cycle after the enable is seen low
  a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
    !enable |=> pwm_out == '0);
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] pwm_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    int    ch;
    int    high;
    int    per;
    string req;
  } pulse_t;
  pulse_t sb_q[$];

  always #5 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) u_pwm_bank (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    reg_we    = 1'b1;
    reg_addr  = AW'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // driver side of the scoreboard: queue an expected pulse, wait until compared
  task automatic expect_pulse(input int ch, input int high, input int per, input string req);
    pulse_t p;
    p.ch = ch; p.high = high; p.per = per; p.req = req;
    sb_q.push_back(p);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: measure one full pulse starting at a fresh rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        pulse_t p;
        int hi, lo, waitc;
        logic prev;
        p = sb_q[0];
        prev = pwm_out[p.ch];
        waitc = 0;
        while (!(prev == 1'b0 && pwm_out[p.ch] == 1'b1) && waitc < 20000) begin
          prev = pwm_out[p.ch];
          @(negedge clk);
          waitc++;
        end
        if (waitc >= 20000) begin
          check({p.req, " no rising edge"}, 0, 1);
        end else begin
          hi = 0; lo = 0;
          while (pwm_out[p.ch] == 1'b1 && hi < 20000) begin hi++; @(negedge clk); end
          while (pwm_out[p.ch] == 1'b0 && lo < 20000) begin lo++; @(negedge clk); end
          check({p.req, " high time"}, hi, p.high);
          check({p.req, " period"}, hi + lo, p.per);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi;
    bit all_ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs after reset", pwm_out, 0);
    reg_read(32'h50, rd); check("R1 control after reset", rd, 0);
    reg_read(0, rd);      check("R1 duty0 after reset", rd, 0);

    // R3: duty words
    reg_write(0,  32'hFFFF_FF64);   // ch0 = 100
    reg_write(4,  32'h0000_0000);   // ch1 = 0
    reg_write(8,  32'h0000_00FF);   // ch2 = 255
    reg_write(12, 32'h0000_000A);   // ch3 = 10
    reg_read(0, rd);  check("R3 duty0 readback", rd, 100);
    reg_read(12, rd); check("R3 duty3 readback", rd, 10);

    // R2: masked control write, enable left 0
    reg_write(32'h50, 32'hFFFF_85F5);
    reg_read(32'h50, rd); check("R2 control mask", rd, 32'hFFFF_85F5 & 32'h7A0F);
    // R7: disabled, outputs stay low
    all_ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwm_out != 0) all_ok = 1'b0;
    end
    check("R7 low while disabled", all_ok, 1);

    // R8: enable with prescale 0, all rise together one cycle later
    reg_write(32'h50, 32'h0000_0200);
    check("R8 still low right after write", pwm_out, 0);
    @(negedge clk);
    check("R8 aligned first rise", pwm_out, 4'b1111);

    // R4 / R5 at prescale 0
    expect_pulse(0, 101, 256, "R5 ch0 duty 100");
    expect_pulse(1, 1,   256, "R5 ch1 duty 0");
    expect_pulse(3, 11,  256, "R4 ch3 duty 10");

    // R6: duty 255 never low
    all_ok = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pwm_out[2] != 1'b1) all_ok = 1'b0;
    end
    check("R6 ch2 constant high", all_ok, 1);

    // R9: duty change mid-pulse keeps the running pulse
    while (!(pwm_out[0] == 1'b1 && pwm_out[1] == 1'b1)) @(negedge clk);
    hi = 0;
    while (pwm_out[0] == 1'b1 && hi < 1000) begin
      hi++;
      if (hi == 10) begin
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'd20;
      end else begin
        reg_we = 1'b0;
      end
      @(negedge clk);
    end
    reg_we = 1'b0;
    check("R9 running pulse unchanged", hi, 101);
    expect_pulse(0, 21, 256, "R9 new duty next period");

    // R2 / R4: split prescale 0x12 -> 19 cycles per tick
    reg_write(32'h50, 32'h0000_0A02);
    reg_read(32'h50, rd); check("R2 split prescale readback", rd, 32'h0A02);
    expect_pulse(3, 11 * 19, 256 * 19, "R4 ch3 prescale 18");
    expect_pulse(1, 19,      256 * 19, "R5 ch1 prescale 18");

    // R7: disable drops every output, including full-scale ch2
    reg_write(32'h50, 32'h0000_0000);
    repeat (2) @(negedge clk);
    check("R7 outputs low after disable", pwm_out, 0);
    all_ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_out != 0) all_ok = 1'b0;
    end
    check("R7 stay low while disabled", all_ok, 1);

    // R10: unmapped writes and reads
    reg_write(32'h40, 32'hFFFF_FFFF);
    reg_write(32'h10, 32'hFFFF_FFFF);
    reg_read(32'h40, rd); check("R10 unmapped read zero", rd, 0);
    reg_read(32'h10, rd); check("R10 missing channel read zero", rd, 0);
    reg_read(32'h50, rd); check("R10 control untouched", rd, 0);
    reg_read(0, rd);      check("R10 duty0 untouched", rd, 20);
    reg_read(12, rd);     check("R10 duty3 untouched", rd, 10);

    // R8: re-enable restarts a common frame
    reg_write(32'h50, 32'h0000_0200);
    @(negedge clk);
    check("R8 aligned rise after re-enable", pwm_out, 4'b1111);
    expect_pulse(0, 21, 256, "R8 ch0 after re-enable");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule